// File: doc/BRIEF.md
# Double-Buffered Time-Slot Interchanger

This block re-orders the byte-wide time slots of one TDM stream. A frame holds 128 slots, numbered 0 to 127. Each incoming slot byte is stored in one of two frame banks. The banks trade roles at every frame start: one bank collects the frame now arriving, while the other still holds the frame before it. For each output slot, a connection table names the source slot to copy, an enable, and a delay-mode bit.

The delay-mode bit is judged against the signed slot delta, output slot minus source slot.
- **Minimum delay (mode 0):** a connection with a positive delta takes its byte from the current frame. A zero or negative delta takes it from the previous frame.
- **Constant delay (mode 1):** the byte always comes from the previous frame, so every connection has a latency of one frame plus the delta. A group of slots therefore keeps its relative order across a frame boundary.

A global control word can replace every per-connection mode bit with one chip-wide value. Table and control writes are staged and take effect only at the next frame start, so a frame is never switched with mixed settings.

Slot bytes enter and leave as valid/ready streams, one output beat per accepted input beat. Back-pressure rules:
- An input beat is taken only when the output register is empty, or is being emptied in the same cycle (`in_ready = !out_valid || out_ready`).
- A held output beat keeps its data and frame marker unchanged until `out_ready` is seen.

Top module: `tsi_switch`

## Requirements
- R1: Each accepted input beat occupies one slot. A beat with `in_sof` high is slot 0; otherwise the slot is the previous beat's slot plus one, modulo 128. `slot_next` shows the slot the next beat without `in_sof` will take.
- R2: Each accepted beat yields exactly one output beat, valid in the following cycle, with `out_sof` high exactly when the beat was slot 0. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the values of `out_data` and `out_sof` hold.
- R3: In minimum-delay mode (mode bit 0) with the source slot below the output slot, the output is the byte received in that source slot earlier in the same frame.
- R4: In minimum-delay mode with the source slot at or above the output slot, the output is the byte received in that source slot during the previous frame.
- R5: In constant-delay mode (mode bit 1), the output is always the source slot's byte from the previous frame.
- R6: When bit 1 of the control word is set, bit 0 of the control word replaces the mode bit of every connection.
- R7: An output slot whose entry has its enable bit clear outputs 0xFF.
- R8: Configuration writes use `cfg_addr` 0 to 127 to select a connection entry, with `cfg_wdata[6:0]` the source slot, `cfg_wdata[7]` the mode bit and `cfg_wdata[8]` the enable. `cfg_addr` 128 selects the control word in `cfg_wdata[1:0]`. A write takes effect only from the first slot-0 beat accepted after the write cycle.
- R9: Writes to `cfg_addr` 129 to 255 change no entry and no control bit.
- R10: After reset every entry is disabled, the control word is 0, `out_valid` is 0, `in_ready` is 1 and `slot_next` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input slot byte valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Input slot byte |
| in_sof | input | 1 | Input beat is slot 0 of a new frame |
| out_valid | output | 1 | Output slot byte valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 8 | Switched output byte |
| out_sof | output | 1 | Output beat is slot 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Entry index 0..127, control word at 128 |
| cfg_wdata | input | 9 | Entry {enable, mode, source} or control bits |
| slot_next | output | 7 | Slot of the next input beat |

## Verification
A swapped or stuck bank pointer shows up as bytes exactly one frame early or late. The error is visible on the output beat one cycle after the affected slot is accepted, and for constant-delay connections it starts in the very next frame. A table entry copied at the wrong moment changes the source or the idle pattern at the first output slot that uses that entry. Mid-frame writes are therefore checked at a slot later in the same frame, where the staged value must not yet appear. A slip of the slot counter shifts every later output of the frame, and `slot_next` exposes it right away.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned SLOT_W = 7;
  localparam int unsigned NSLOT  = 1 << SLOT_W;
  localparam int unsigned ADDR_W = SLOT_W + 1;

  typedef logic [SLOT_W-1:0] slot_t;

  // one connection entry, as written through cfg_wdata
  typedef struct packed {
    logic  en;
    logic  cdly;
    slot_t src;
  } conn_t;

  localparam int unsigned CONN_W = $bits(conn_t);

  // global mode control: bit 1 forces, bit 0 is the forced mode
  typedef struct packed {
    logic force_on;
    logic force_val;
  } gctl_t;
endpackage

// File: rtl/tsi_slot_seq.sv
module tsi_slot_seq
  import tsi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sof,
  output slot_t slot,
  output logic  boundary,
  output logic  bank_now,
  output logic  bank_q,
  output slot_t next_slot
);
  slot_t nxt_q;

  assign slot      = sof ? '0 : nxt_q;
  assign boundary  = beat && (slot == '0);
  assign bank_now  = boundary ? ~bank_q : bank_q;
  assign next_slot = nxt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_q  <= '0;
      bank_q <= 1'b0;
    end else if (beat) begin
      nxt_q  <= slot + 1'b1;
      bank_q <= bank_now;
    end
  end

  // R1: a frame-start beat puts the counter at slot 1
  p_sof_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beat && sof |=> next_slot == slot_t'(1));

  // R4: banks trade roles on every slot-0 beat
  p_bank_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> bank_q != $past(bank_q));

  // R3: no bank swap inside a frame
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(bank_q));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CONN_W-1:0] cfg_wdata,
  input  logic              boundary,
  input  slot_t             rd_slot,
  output conn_t             rd_entry,
  output gctl_t             ctl
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NSLOT);

  conn_t stage_q [NSLOT];
  conn_t act_q   [NSLOT];
  gctl_t ctl_stage_q, ctl_act_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
        act_q[g]   <= '0;
      end else begin
        if (cfg_we && cfg_addr == ADDR_W'(g)) stage_q[g] <= conn_t'(cfg_wdata);
        if (boundary) act_q[g] <= stage_q[g];
      end
    end

    // R8: live entries change only at a frame start
    p_live_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(act_q[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_stage_q <= '0;
      ctl_act_q   <= '0;
    end else begin
      if (cfg_we && cfg_addr == CTL_ADDR) ctl_stage_q <= gctl_t'(cfg_wdata[1:0]);
      if (boundary) ctl_act_q <= ctl_stage_q;
    end
  end

  // on the slot-0 beat the staged settings are already in force
  assign rd_entry = boundary ? stage_q[rd_slot] : act_q[rd_slot];
  assign ctl      = boundary ? ctl_stage_q : ctl_act_q;

  // R6: global control changes only at a frame start
  p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(ctl_act_q));
endmodule

// File: rtl/tsi_frame_buf.sv
module tsi_frame_buf
  import tsi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  slot_t             wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  slot_t             rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [2][NSLOT];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_bank][wr_slot] <= wr_data;
  end

  assign rd_data = mem_q[rd_bank][rd_slot];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CONN_W-1:0] cfg_wdata,
  output slot_t             slot_next
);
  localparam logic [DATA_W-1:0] IDLE = '1;

  logic              beat;
  slot_t             slot;
  logic              boundary, bank_now, bank_q;
  conn_t             entry;
  gctl_t             ctl;
  logic              mode_eff, use_prev, rd_bank;
  logic [DATA_W-1:0] rd_data, sw_byte;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;

  tsi_slot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .sof       (in_sof),
    .slot      (slot),
    .boundary  (boundary),
    .bank_now  (bank_now),
    .bank_q    (bank_q),
    .next_slot (slot_next)
  );

  tsi_conn_mem u_conn (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .boundary  (boundary),
    .rd_slot   (slot),
    .rd_entry  (entry),
    .ctl       (ctl)
  );

  // delay mode and bank choice for this output slot
  assign mode_eff = ctl.force_on ? ctl.force_val : entry.cdly;
  assign use_prev = mode_eff || (entry.src >= slot);
  assign rd_bank  = use_prev ? ~bank_now : bank_now;

  tsi_frame_buf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .wr_en   (beat),
    .wr_bank (bank_now),
    .wr_slot (slot),
    .wr_data (in_data),
    .rd_bank (rd_bank),
    .rd_slot (entry.src),
    .rd_data (rd_data)
  );

  assign sw_byte = entry.en ? rd_data : IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= IDLE;
      out_sof   <= 1'b0;
    end else if (beat) begin
      out_valid <= 1'b1;
      out_data  <= sw_byte;
      out_sof   <= (slot == '0);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled output beat holds
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  // R2: every accepted beat appears next cycle
  p_beat_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> out_valid);

  // R1: frame marker follows a frame-start input beat
  p_sof_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beat && in_sof |=> out_sof);

  // R7: a disabled entry drives the idle pattern
  p_idle_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !entry.en |=> out_data == IDLE);
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;
  logic [6:0] slot_next;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_switch i_tsi_switch (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .slot_next(slot_next)
  );

  // reference model built from the requirements
  logic [8:0] m_stage [128];
  logic [8:0] m_live  [128];
  logic [1:0] m_cstage, m_clive;
  logic [7:0] m_prev [128];
  logic [7:0] m_cur  [128];
  bit         k_prev [128];
  bit         k_cur  [128];
  int         m_nslot;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 128; i++) begin
      m_stage[i] = '0; m_live[i] = '0; k_prev[i] = 0; k_cur[i] = 0;
      m_prev[i] = '0; m_cur[i] = '0;
    end
    m_cstage = '0; m_clive = '0; m_nslot = 0;
  endtask

  task automatic model_step(input logic [7:0] d, input bit sof,
                            output logic [7:0] ex, output bit kn,
                            output int s, output string tag);
    logic [8:0] e;
    bit mode, prev;
    s = sof ? 0 : m_nslot;
    if (s == 0) begin
      m_live = m_stage; m_clive = m_cstage;
      m_prev = m_cur;   k_prev  = k_cur;
      for (int i = 0; i < 128; i++) k_cur[i] = 0;
    end
    e = m_live[s];
    mode = m_clive[1] ? m_clive[0] : e[7];
    prev = mode || (int'(e[6:0]) >= s);
    if (!e[8]) begin
      ex = 8'hFF; kn = 1; tag = "R7";
    end else begin
      ex = prev ? m_prev[e[6:0]] : m_cur[e[6:0]];
      kn = prev ? k_prev[e[6:0]] : k_cur[e[6:0]];
      tag = m_clive[1] ? "R6" : (mode ? "R5" : (prev ? "R4" : "R3"));
    end
    m_cur[s] = d; k_cur[s] = 1;
    m_nslot = (s + 1) % 128;
  endtask

  // at a negedge: present one beat, check its output one cycle later
  task automatic beat(input logic [7:0] d, input bit sof, input string force_tag);
    logic [7:0] ex; bit kn; int s; string tag;
    in_valid = 1'b1; in_data = d; in_sof = sof;
    check(in_ready == 1'b1, "R2 in_ready", in_ready, 1);
    model_step(d, sof, ex, kn, s, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(out_valid == 1'b1, "R2 out_valid", out_valid, 1);
    check(out_sof == (s == 0), "R1 out_sof", out_sof, (s == 0));
    if (kn) check(out_data == ex, tag, out_data, ex);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sof = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] a, input logic [8:0] w);
    in_valid = 1'b0; in_sof = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    if (a < 128) m_stage[a] = w;
    else if (a == 128) m_cstage = w[1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [8:0] ent(input bit en, input bit md, input int src);
    return {en, md, 7'(src)};
  endfunction

  task automatic frame(input int fno);
    for (int s = 0; s < 128; s++) beat(8'(fno * 37 + s * 5), s == 0, "");
  endtask

  initial begin
    logic [7:0] e1, e2; bit k1, k2; int s1, s2; string t1, t2;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    check(slot_next == 7'd0, "R10 slot_next", slot_next, 0);

    // all entries disabled after reset -> idle fill (R7, R10)
    frame(1);
    check(slot_next == 7'd0, "R1 wrap", slot_next, 0);

    // directed connections: forward, reverse, zero, constant, extremes
    cfg(8'd10, ent(1, 0, 5));
    cfg(8'd5,  ent(1, 0, 10));
    cfg(8'd20, ent(1, 0, 20));
    cfg(8'd30, ent(1, 1, 3));
    cfg(8'd0,  ent(1, 0, 127));
    cfg(8'd127, ent(1, 0, 0));
    cfg(8'd40, ent(1, 1, 90));
    for (int f = 2; f < 5; f++) frame(f);

    // R6: force constant delay, then force minimum delay
    cfg(8'd128, 9'b11);
    frame(5); frame(6);
    cfg(8'd128, 9'b10);
    frame(7); frame(8);
    cfg(8'd128, 9'b00);
    frame(9);

    // R8: mid-frame write must wait for the next frame start
    for (int s = 0; s < 50; s++) beat(8'(s + 3), s == 0, "");
    cfg(8'd100, ent(1, 0, 1));
    for (int s = 50; s < 128; s++) beat(8'(s + 3), 0, s == 100 ? "R8" : "");
    for (int s = 0; s < 128; s++) beat(8'(s + 9), s == 0, s == 100 ? "R8" : "");

    // R9: out-of-range address must not alias onto slot 72 or control
    cfg(8'd200, ent(1, 1, 0));
    cfg(8'd129, 9'b11);
    for (int s = 0; s < 128; s++) beat(8'(s), s == 0, (s == 72 || s == 10) ? "R9" : "");

    // R1: early frame start in mid-frame
    for (int s = 0; s < 60; s++) beat(8'(s * 3), s == 0, "");
    beat(8'hA5, 1, "R1");
    check(slot_next == 7'd1, "R1 slot_next", slot_next, 1);
    for (int s = 1; s < 128; s++) beat(8'(s ^ 8'h5A), 0, "");

    // R2: back-pressure
    idle();
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'h11; in_sof = 1'b1;
    model_step(8'h11, 1, e1, k1, s1, t1);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 stall valid", out_valid, 1);
    check(in_ready == 1'b0, "R2 stall ready", in_ready, 0);
    if (k1) check(out_data == e1, "R2 first", out_data, e1);
    in_data = 8'h22; in_sof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_data == e1 && out_sof == 1'b1, "R2 hold", out_data, e1);
      check(in_ready == 1'b0, "R2 hold ready", in_ready, 0);
    end
    check(slot_next == 7'd1, "R2 no extra beat", slot_next, 1);
    out_ready = 1'b1;
    model_step(8'h22, 0, e2, k2, s2, t2);
    @(negedge clk);
    check(out_valid == 1'b1 && out_sof == 1'b0, "R2 release", out_sof, 0);
    if (k2) check(out_data == e2, "R2 second", out_data, e2);
    for (int s = 2; s < 128; s++) beat(8'(s), 0, "");

    // random maps, control and data
    for (int r = 0; r < 3; r++) begin
      for (int a = 0; a < 128; a++)
        cfg(8'(a), 9'($urandom_range(0, 511)));
      cfg(8'd128, 9'($urandom_range(0, 3)));
      for (int f = 0; f < 3; f++)
        for (int s = 0; s < 128; s++)
          beat(8'($urandom_range(0, 255)), s == 0, "");
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule